// File: doc/BRIEF.md
# Two-wire serial EEPROM target

This block is the target side of a two-wire (I2C) bus, presenting an 8192-byte non-volatile-style store to a bus controller. It runs on a fast system clock. SCL and SDA are brought in as plain inputs and synchronised. The block drives the data line only by pulling it low: the output `sdaPullLow` is meant to enable an open-drain driver. Three address-select inputs set the low bits of the target's bus address, and a write-protect input keeps the array from being modified.

A controller writes by sending the target address, two word-address bytes and one or more data bytes. It reads by setting the word address in a write phase, issuing a repeated start, and clocking bytes out of the target until it answers one with a not-acknowledge. Bytes written in one transaction fill consecutive locations inside one 32-byte page. Bytes read in one transaction walk the whole array.

Top module: `serial_eeprom_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 4'b1010 followed by addrSel[2:0] (bit 0 is read=1/write=0). Any other address byte gets no acknowledge, and the target then pulls SDA for nothing until the next start condition.
- R2: In a write, the first byte after the address gives the upper 5 bits of the 13-bit word address in its bits 4:0, and its bits 7:5 are ignored. The second byte gives the lower 8 bits. The first data byte is stored at that word address, and every one of these bytes is acknowledged.
- R3: Each further data byte in the same write goes to the next location. Only the low 5 address bits advance, so a byte past the end of a 32-byte page lands at the start of the same page. Locations outside that page are left as they were.
- R4: While writeProtect is 1, data bytes of a write get no acknowledge and the array is not modified. Device and word-address bytes are still acknowledged.
- R5: After a write-mode address phase, a repeated start and an address byte with bit 0 = 1, the target returns the byte at the word address, MSB first. Each bit is stable while SCL is high.
- R6: In a read, each byte the controller acknowledges (SDA low on the ninth clock) advances the full 13-bit pointer, wrapping from 8191 to 0, and the next byte follows.
- R7: A not-acknowledge from the controller ends the read. The target leaves SDA released on the clocks that follow.
- R8: The target asserts an acknowledge only after it has seen the falling edge of the eighth clock. It holds the acknowledge through the whole high phase of the ninth clock and releases it after that clock falls.
- R9: After reset and after a stop condition the target leaves SDA released, and a new start begins a fresh transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (resolved bus) |
| sdaPullLow | output | 1 | 1 = pull the data line low, 0 = release |
| addrSel | input | 3 | Low three bits of the target bus address |
| writeProtect | input | 1 | 1 = array may not be modified |

## Verification
The bench builds the block with its default parameters: a 13-bit pointer, 5-bit page offset and two synchroniser stages. The array is addressed directly, so the page edge at offsets 30/31 and the array edge at 8191 are reached by writing a starting address instead of by counting through the array. An SCL half period of ten system clocks gives the synchroniser and edge detector time to settle. This places every acknowledge and data bit well inside the low phase and lets the bench sample SDA both early and late in each high phase.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLevel;
  } busEvents_t;

  typedef struct packed {
    logic shiftIn;
    logic loadHigh;
    logic loadLow;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
    logic incSeq;
  } dpStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_HACK
  } ctrlState_t;

  typedef enum logic [1:0] {
    ROLE_DEV,
    ROLE_AHI,
    ROLE_ALO,
    ROLE_DATA
  } byteRole_t;

endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync
  import eeprom_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output busEvents_t ev
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic          sclQ;
  logic          sdaQ;
  logic          sclS;
  logic          sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[LAST-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
      sclQ    <= sclPipe[LAST];
      sdaQ    <= sdaPipe[LAST];
    end
  end

  assign sclS = sclPipe[LAST];
  assign sdaS = sdaPipe[LAST];

  always_comb begin
    ev.sclRise   = sclS & ~sclQ;
    ev.sclFall   = ~sclS & sclQ;
    ev.startSeen = sclS & sclQ & sdaQ & ~sdaS;
    ev.stopSeen  = sclS & sclQ & ~sdaQ & sdaS;
    ev.sdaLevel  = sdaS;
  end

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvents_t ev,
  input  logic [2:0] addrSel,
  input  logic       writeProtect,
  input  logic [7:0] rxByte,
  output dpStrobes_t st,
  output logic       driveAck,
  output logic       driveData
);
  ctrlState_t state;
  byteRole_t  role;
  logic [3:0] bitCnt;
  logic       goTx;
  logic       hostAcked;
  logic       byteDone;
  logic       addrHit;

  assign byteDone = (state == ST_RX) && ev.sclFall && (bitCnt == 4'd8);
  assign addrHit  = (rxByte[7:1] == {DEV_CODE, addrSel});

  always_comb begin
    st           = '0;
    st.shiftIn   = (state == ST_RX) && ev.sclRise && (bitCnt < 4'd8);
    st.loadHigh  = byteDone && (role == ROLE_AHI);
    st.loadLow   = byteDone && (role == ROLE_ALO);
    st.writeByte = byteDone && (role == ROLE_DATA) && !writeProtect;
    st.loadTx    = ((state == ST_ACK) && ev.sclFall && goTx) ||
                   ((state == ST_HACK) && ev.sclFall && hostAcked);
    st.shiftTx   = (state == ST_TX) && ev.sclFall && (bitCnt < 4'd8);
    st.incSeq    = (state == ST_HACK) && ev.sclRise && !ev.sdaLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      role      <= ROLE_DEV;
      bitCnt    <= '0;
      goTx      <= 1'b0;
      hostAcked <= 1'b0;
      driveAck  <= 1'b0;
      driveData <= 1'b0;
    end else if (ev.startSeen) begin
      state     <= ST_RX;
      role      <= ROLE_DEV;
      bitCnt    <= '0;
      driveAck  <= 1'b0;
      driveData <= 1'b0;
    end else if (ev.stopSeen) begin
      state     <= ST_IDLE;
      driveAck  <= 1'b0;
      driveData <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (ev.sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            goTx <= 1'b0;
            unique case (role)
              ROLE_DEV: begin
                if (addrHit) begin
                  driveAck <= 1'b1;
                  goTx     <= rxByte[0];
                  role     <= ROLE_AHI;
                  state    <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ROLE_AHI: begin
                driveAck <= 1'b1;
                role     <= ROLE_ALO;
                state    <= ST_ACK;
              end
              ROLE_ALO: begin
                driveAck <= 1'b1;
                role     <= ROLE_DATA;
                state    <= ST_ACK;
              end
              default: begin
                driveAck <= !writeProtect;
                state    <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            driveAck <= 1'b0;
            bitCnt   <= '0;
            if (goTx) begin
              state     <= ST_TX;
              driveData <= 1'b1;
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (ev.sclRise) bitCnt <= bitCnt + 4'd1;
          if (ev.sclFall && bitCnt == 4'd8) begin
            driveData <= 1'b0;
            hostAcked <= 1'b0;
            state     <= ST_HACK;
          end
        end
        ST_HACK: begin
          if (ev.sclRise) hostAcked <= !ev.sdaLevel;
          if (ev.sclFall) begin
            if (hostAcked) begin
              state     <= ST_TX;
              driveData <= 1'b1;
              bitCnt    <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R8: an acknowledge is raised only right after a falling SCL edge
  p_ack_after_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveAck) |-> $past(ev.sclFall));

  // R8: an acknowledge is dropped only after SCL falls or on a bus condition
  p_ack_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveAck) |-> ($past(ev.sclFall) || $past(ev.startSeen) || $past(ev.stopSeen)));

  // R5: data output starts only after a falling SCL edge
  p_tx_after_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveData) |-> $past(ev.sclFall));

  // R1: an idle target drives nothing
  p_silent_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!driveAck && !driveData));

endmodule

// File: rtl/eeprom_dpath.sv
module eeprom_dpath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobes_t st,
  input  logic       sdaLevel,
  output logic [7:0] rxByte,
  output logic       txMsb
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        hiByte;
  logic [7:0]        rxShift;
  logic [7:0]        txShift;

  always_ff @(posedge clk) begin
    if (st.writeByte) mem[ptr] <= rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      hiByte  <= '0;
      rxShift <= '0;
      txShift <= '1;
    end else begin
      if (st.shiftIn) rxShift <= {rxShift[6:0], sdaLevel};

      if (st.loadTx)       txShift <= mem[ptr];
      else if (st.shiftTx) txShift <= {txShift[6:0], 1'b1};

      if (st.loadHigh) hiByte <= rxShift;

      if (st.loadLow)
        ptr <= ADDR_W'({hiByte, rxShift});
      else if (st.writeByte)
        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      else if (st.incSeq)
        ptr <= ptr + 1'b1;
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];

  // R3: writing a byte never moves the pointer out of its page
  p_page_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.writeByte |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
  import eeprom_pkg::*;
#(
  parameter int         ADDR_W      = 13,
  parameter int         PAGE_W      = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  input  logic [2:0] addrSel,
  input  logic       writeProtect
);
  busEvents_t ev;
  dpStrobes_t st;
  logic [7:0] rxByte;
  logic       txMsb;
  logic       driveAck;
  logic       driveData;

  eeprom_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .ev    (ev)
  );

  eeprom_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ev           (ev),
    .addrSel      (addrSel),
    .writeProtect (writeProtect),
    .rxByte       (rxByte),
    .st           (st),
    .driveAck     (driveAck),
    .driveData    (driveData)
  );

  eeprom_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .sdaLevel (ev.sdaLevel),
    .rxByte   (rxByte),
    .txMsb    (txMsb)
  );

  assign sdaPullLow = driveAck | (driveData & ~txMsb);

endmodule

// File: tb/serial_eeprom_target_bench.sv
module serial_eeprom_target_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       hostSda = 1'b1;
  logic [2:0] addrSel = 3'b101;
  logic       writeProtect = 1'b0;
  logic       sdaPullLow;
  wire        sdaBus;

  int  nChecks = 0;
  int  nFail = 0;
  logic preAckPull;
  logic ackHeld;
  logic [7:0] rdBuf [4];

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  always #10 clk = ~clk;

  assign sdaBus = hostSda & ~sdaPullLow;

  serial_eeprom_target u_serial_eeprom_target (
    .clk          (clk),
    .rstN         (rstN),
    .sclIn        (scl),
    .sdaIn        (sdaBus),
    .sdaPullLow   (sdaPullLow),
    .addrSel      (addrSel),
    .writeProtect (writeProtect)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    waitClk(5); hostSda = 1'b1; waitClk(5); scl = 1'b1;
    waitClk(10); hostSda = 1'b0; waitClk(10); scl = 1'b0;
  endtask

  task automatic busStop();
    waitClk(5); hostSda = 1'b0; waitClk(5); scl = 1'b1;
    waitClk(10); hostSda = 1'b1; waitClk(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      waitClk(5); hostSda = b[i]; waitClk(5); scl = 1'b1; waitClk(10);
      if (i == 0) preAckPull = sdaPullLow;
      scl = 1'b0;
    end
    waitClk(5); hostSda = 1'b1; waitClk(5); scl = 1'b1;
    waitClk(3); acked = !sdaBus;
    waitClk(6); ackHeld = (sdaBus == !acked);
    waitClk(1); scl = 1'b0;
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitClk(5); hostSda = 1'b1; waitClk(5); scl = 1'b1;
      waitClk(5); b[i] = sdaBus; waitClk(5); scl = 1'b0;
    end
    waitClk(5); hostSda = hostAck ? 1'b0 : 1'b1; waitClk(5); scl = 1'b1;
    waitClk(10); scl = 1'b0;
  endtask

  task automatic writeOne(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d,
                          input string tag);
    logic a;
    busStart();
    sendByte(DEV_W, a); check(a, {tag, " dev ack"}, a, 1);
    sendByte(hi, a);    check(a, {tag, " hi ack"}, a, 1);
    sendByte(lo, a);    check(a, {tag, " lo ack"}, a, 1);
    sendByte(d, a);     check(a, {tag, " data ack"}, a, 1);
    busStop();
  endtask

  task automatic readSeq(input logic [7:0] hi, input logic [7:0] lo, input int n);
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(DEV_W, a);
    sendByte(hi, a);
    sendByte(lo, a);
    busStart();
    sendByte(DEV_R, a);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      rdBuf[k] = b;
    end
    busStop();
  endtask

  task automatic t_reset();
    check(sdaPullLow == 1'b0, "R9 reset releases SDA", sdaPullLow, 0);
  endtask

  task automatic t_addr_match();
    logic a;
    busStart();
    sendByte(DEV_W, a); check(a == 1'b1, "R1 matching address acked", a, 1);
    busStop();
    busStart();
    sendByte(8'hA0, a); check(a == 1'b0, "R1 foreign address not acked", a, 0);
    sendByte(8'h00, a); check(a == 1'b0, "R1 silent after mismatch", a, 0);
    busStop();
  endtask

  task automatic t_byte_write();
    writeOne(8'hE1, 8'h23, 8'hA5, "R2");
    readSeq(8'h01, 8'h23, 1);
    check(rdBuf[0] == 8'hA5, "R2 R5 random read of written byte", rdBuf[0], 8'hA5);
  endtask

  task automatic t_page_write();
    logic a;
    writeOne(8'h1F, 8'h40, 8'h77, "R3 guard");
    busStart();
    sendByte(DEV_W, a); sendByte(8'h1F, a); sendByte(8'h3E, a);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a); sendByte(8'h44, a);
    check(a == 1'b1, "R3 page bytes acked", a, 1);
    busStop();
    readSeq(8'h1F, 8'h3E, 2);
    check(rdBuf[0] == 8'h11, "R3 offset 30", rdBuf[0], 8'h11);
    check(rdBuf[1] == 8'h22, "R3 offset 31", rdBuf[1], 8'h22);
    readSeq(8'h1F, 8'h20, 2);
    check(rdBuf[0] == 8'h33, "R3 wrapped to offset 0", rdBuf[0], 8'h33);
    check(rdBuf[1] == 8'h44, "R3 wrapped to offset 1", rdBuf[1], 8'h44);
    readSeq(8'h1F, 8'h40, 1);
    check(rdBuf[0] == 8'h77, "R3 next page untouched", rdBuf[0], 8'h77);
  endtask

  task automatic t_write_protect();
    logic a;
    writeProtect = 1'b1;
    busStart();
    sendByte(DEV_W, a); check(a == 1'b1, "R4 dev acked under protect", a, 1);
    sendByte(8'h01, a); sendByte(8'h23, a);
    check(a == 1'b1, "R4 address acked under protect", a, 1);
    sendByte(8'h5A, a); check(a == 1'b0, "R4 data nacked under protect", a, 0);
    busStop();
    writeProtect = 1'b0;
    readSeq(8'h01, 8'h23, 1);
    check(rdBuf[0] == 8'hA5, "R4 array unchanged", rdBuf[0], 8'hA5);
  endtask

  task automatic t_seq_wrap();
    writeOne(8'h1F, 8'hFF, 8'hC3, "R6 last");
    writeOne(8'h00, 8'h00, 8'h3C, "R6 first");
    readSeq(8'h1F, 8'hFF, 2);
    check(rdBuf[0] == 8'hC3, "R6 byte at 8191", rdBuf[0], 8'hC3);
    check(rdBuf[1] == 8'h3C, "R6 wrapped to 0", rdBuf[1], 8'h3C);
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(DEV_W, a); sendByte(8'h1F, a); sendByte(8'hFF, a);
    busStart();
    sendByte(DEV_R, a);
    recvByte(1'b0, b);
    check(b == 8'hC3, "R7 byte before nack", b, 8'hC3);
    waitClk(5); hostSda = 1'b1; waitClk(5); scl = 1'b1; waitClk(5);
    check(sdaBus == 1'b1, "R7 SDA released after nack", sdaBus, 1);
    waitClk(5); scl = 1'b0;
    busStop();
  endtask

  task automatic t_ack_timing();
    logic a;
    busStart();
    sendByte(DEV_W, a);
    check(preAckPull == 1'b0, "R8 no pull before eighth fall", preAckPull, 0);
    check(a == 1'b1 && ackHeld == 1'b1, "R8 ack held through high phase", ackHeld, 1);
    waitClk(6);
    check(sdaPullLow == 1'b0, "R8 ack released after ninth fall", sdaPullLow, 0);
    busStop();
  endtask

  task automatic t_stop_restart();
    logic a;
    check(sdaPullLow == 1'b0, "R9 released after stop", sdaPullLow, 0);
    busStart();
    sendByte(DEV_W, a); check(a == 1'b1, "R9 fresh transaction acked", a, 1);
    busStop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    t_reset();
    t_addr_match();
    t_byte_write();
    t_page_write();
    t_write_protect();
    t_seq_wrap();
    t_nack_release();
    t_ack_timing();
    t_stop_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule